// File: doc/BRIEF.md
# Completion Interrupt Message Coalescer

This block decides when a descriptor-processing engine tells the host that work has finished. It does not drive an interrupt wire. It raises a single request to write a programmed 32-bit data word to a programmed 48-bit address, which is a message-signalled interrupt. A neighbouring bus master carries out that write and returns an acknowledge. Coalescing avoids one message per descriptor. A message goes out once the count of completed but unreclaimed descriptors reaches a programmed threshold. It can also go out once an optional idle timer, started by the first unsignalled completion, has seen enough ticks.

Only completions whose descriptor asked for an interrupt can arm the block. A message is never sent while the pending count is zero, because such a message would be spurious. Exactly one request is outstanding at a time. The acknowledge clears the armed state and the timer. Flagged completions that arrive while a request is in flight, including in the acknowledge cycle itself, are remembered and re-arm the block at once.

Software programs the block through a write-only register port. The byte offsets listed in the requirements are part of the programming model.

Top module: `irq_msg_coalescer`

## Requirements
- R1: While `rst` is high, and after it, `msg_req` is low and `msg_addr` and `msg_data` are zero until a message is raised.
- R2: Offset 0x018 bits [14:0] hold the count threshold. If the block is armed, `pend_cnt` is non-zero, and `pend_cnt` is greater than or equal to the threshold, `msg_req` rises on the clock edge after those inputs are sampled. A flagged completion therefore causes the request two edges after it is sampled. A count below the threshold raises nothing.
- R3: A completion with `done_irq` low never arms the block and never causes a message.
- R4: No message is raised while `pend_cnt` is zero, whatever the threshold and timer state.
- R5: Offset 0x810 bits [12:0] hold the timer threshold N, and offset 0x018 bit 18 enables the timer. When the timer is enabled and the block is armed, the tick that brings the count of ticks since arming to max(N,1) is recorded, and `msg_req` rises one edge later.
- R6: While the timer enable is clear, ticks are not counted and cause no message. Setting the enable later lets later ticks count.
- R7: A timer threshold of 0 with the timer enabled raises a message on the first tick after a flagged completion.
- R8: A raised `msg_req` stays high with stable `msg_addr`/`msg_data` until `msg_ack` is sampled, and each arming yields exactly one message. The address and data are the register values at the moment the request is raised.
- R9: The edge that samples `msg_ack` with `msg_req` high drops `msg_req` and clears the armed state and the timer. Without a further flagged completion no new message follows, even if the count stays at or above the threshold.
- R10: A flagged completion sampled while a request is outstanding, including in the acknowledge cycle, leaves the block armed after the acknowledge. A new request then rises one edge after `msg_req` drops.
- R11: Offset 0x014 holds the message data word. Offset 0x050 holds address bits [31:0]. Offset 0x054 bits [15:0] hold address bits [47:32], and its upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Register byte offset |
| reg_wr_data | input | 32 | Register write data |
| done_valid | input | 1 | One descriptor completed this cycle |
| done_irq | input | 1 | The completed descriptor requested an interrupt |
| pend_cnt | input | 15 | Completed, not yet reclaimed descriptor count |
| tick | input | 1 | Timer time base pulse |
| msg_ack | input | 1 | Message write accepted |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 48 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
Two events can fall in the same cycle: the acknowledge of an outstanding message and a new flagged completion. The bench provokes this by driving `msg_ack`, `done_valid` and `done_irq` together while `msg_req` is high. It then expects `msg_req` low on the next edge and high again on the edge after. The scoreboard must also see exactly one further message, with the current address and data. A second case places the completion a few cycles before the acknowledge, to show that the remembered completion rather than the coincidence re-arms the block.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int REG_AW  = 12;
    localparam int REG_DW  = 32;
    localparam int CNT_W   = 15;
    localparam int TMR_W   = 13;
    localparam int MADDR_W = 48;
    localparam int MDATA_W = 32;
    localparam int AHI_W   = MADDR_W - 32;
    localparam int TEN_BIT = 18;

    localparam logic [REG_AW-1:0] OFS_MDATA = 12'h014;
    localparam logic [REG_AW-1:0] OFS_THR   = 12'h018;
    localparam logic [REG_AW-1:0] OFS_ALO   = 12'h050;
    localparam logic [REG_AW-1:0] OFS_AHI   = 12'h054;
    localparam logic [REG_AW-1:0] OFS_TMO   = 12'h810;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt_thr;
        logic               tmr_en;
        logic [TMR_W-1:0]   tmr_thr;
        logic [MADDR_W-1:0] maddr;
        logic [MDATA_W-1:0] mdata;
    } cfg_t;

    // field extraction from a full register word
    function automatic logic [CNT_W-1:0] f_cnt_thr(input logic [REG_DW-1:0] w);
        return w[CNT_W-1:0];
    endfunction

    function automatic logic f_tmr_en(input logic [REG_DW-1:0] w);
        return w[TEN_BIT];
    endfunction

    function automatic logic [TMR_W-1:0] f_tmr_thr(input logic [REG_DW-1:0] w);
        return w[TMR_W-1:0];
    endfunction

    function automatic logic [AHI_W-1:0] f_addr_hi(input logic [REG_DW-1:0] w);
        return w[AHI_W-1:0];
    endfunction

    function automatic logic [TMR_W-1:0] sat_inc(input logic [TMR_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    // the current tick completes the timeout window (threshold 0 acts as 1)
    function automatic logic tick_due(input logic [TMR_W-1:0] cnt,
                                      input logic [TMR_W-1:0] thr);
        return ({1'b0, cnt} + 1'b1) >= {1'b0, thr};
    endfunction
endpackage

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output cfg_t              cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                OFS_MDATA: cfg_q.mdata <= wr_data;
                OFS_THR: begin
                    cfg_q.cnt_thr <= f_cnt_thr(wr_data);
                    cfg_q.tmr_en  <= f_tmr_en(wr_data);
                end
                OFS_ALO: cfg_q.maddr[31:0]        <= wr_data;
                OFS_AHI: cfg_q.maddr[MADDR_W-1:32] <= f_addr_hi(wr_data);
                OFS_TMO: cfg_q.tmr_thr <= f_tmr_thr(wr_data);
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/irqc_timer.sv
`timescale 1ns/1ps
module irqc_timer
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done_valid,
    input  logic             done_irq,
    input  logic             tick,
    input  logic             tmr_en,
    input  logic [TMR_W-1:0] tmr_thr,
    input  logic             msg_busy,
    input  logic             msg_done,
    output logic             armed,
    output logic             tmo_hit
);
    logic             armed_q;
    logic             late_q;
    logic             tmo_q;
    logic [TMR_W-1:0] tcnt_q;
    logic             flag_in;

    assign flag_in = done_valid && done_irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            late_q  <= 1'b0;
            tmo_q   <= 1'b0;
            tcnt_q  <= '0;
        end else if (msg_done) begin
            armed_q <= flag_in || late_q;
            late_q  <= 1'b0;
            tmo_q   <= 1'b0;
            tcnt_q  <= '0;
        end else begin
            if (flag_in) begin
                armed_q <= 1'b1;
            end
            if (flag_in && msg_busy) begin
                late_q <= 1'b1;
            end
            if (armed_q && tmr_en && tick) begin
                tcnt_q <= sat_inc(tcnt_q);
                if (tick_due(tcnt_q, tmr_thr)) begin
                    tmo_q <= 1'b1;
                end
            end
        end
    end

    assign armed   = armed_q;
    assign tmo_hit = tmo_q;

    // R3
    no_unflagged_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !flag_in) |=> !armed_q);

    // R6
    tmr_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!tmr_en && !tmo_q) |=> !tmo_q);

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_done && !flag_in && !late_q) |=> (!armed_q && !tmo_q && tcnt_q == '0));
endmodule

// File: rtl/irqc_msg.sv
`timescale 1ns/1ps
module irqc_msg
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               armed,
    input  logic               tmo_hit,
    input  logic               tmr_en,
    input  logic [CNT_W-1:0]   pend_cnt,
    input  logic [CNT_W-1:0]   cnt_thr,
    input  logic [MADDR_W-1:0] maddr,
    input  logic [MDATA_W-1:0] mdata,
    input  logic               msg_ack,
    output logic               msg_req,
    output logic [MADDR_W-1:0] msg_addr,
    output logic [MDATA_W-1:0] msg_data,
    output logic               msg_done
);
    logic               req_q;
    logic [MADDR_W-1:0] addr_q;
    logic [MDATA_W-1:0] data_q;
    logic               nonzero;
    logic               cnt_hit;
    logic               fire;

    assign nonzero = pend_cnt != '0;
    assign cnt_hit = pend_cnt >= cnt_thr;
    assign fire    = !req_q && armed && nonzero && (cnt_hit || (tmr_en && tmo_hit));

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (fire) begin
            req_q  <= 1'b1;
            addr_q <= maddr;
            data_q <= mdata;
        end else if (req_q && msg_ack) begin
            req_q <= 1'b0;
        end
    end

    assign msg_req  = req_q;
    assign msg_addr = addr_q;
    assign msg_data = data_q;
    assign msg_done = req_q && msg_ack;

    // R8
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && !msg_ack) |=> req_q);

    // R8
    stable_msg_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && !msg_ack) |=> ($stable(addr_q) && $stable(data_q)));

    // R4
    no_empty_msg_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_q && pend_cnt == '0) |=> !req_q);

    // R3
    needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_q && !armed) |=> !req_q);

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q && msg_ack) |=> !req_q);
endmodule

// File: rtl/irq_msg_coalescer.sv
`timescale 1ns/1ps
module irq_msg_coalescer
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [REG_AW-1:0]  reg_wr_addr,
    input  logic [REG_DW-1:0]  reg_wr_data,
    input  logic               done_valid,
    input  logic               done_irq,
    input  logic [CNT_W-1:0]   pend_cnt,
    input  logic               tick,
    input  logic               msg_ack,
    output logic               msg_req,
    output logic [MADDR_W-1:0] msg_addr,
    output logic [MDATA_W-1:0] msg_data
);
    cfg_t cfg;
    logic armed;
    logic tmo_hit;
    logic msg_done;

    irqc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .cfg     (cfg)
    );

    irqc_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .done_valid (done_valid),
        .done_irq   (done_irq),
        .tick       (tick),
        .tmr_en     (cfg.tmr_en),
        .tmr_thr    (cfg.tmr_thr),
        .msg_busy   (msg_req),
        .msg_done   (msg_done),
        .armed      (armed),
        .tmo_hit    (tmo_hit)
    );

    irqc_msg u_msg (
        .clk      (clk),
        .rst      (rst),
        .armed    (armed),
        .tmo_hit  (tmo_hit),
        .tmr_en   (cfg.tmr_en),
        .pend_cnt (pend_cnt),
        .cnt_thr  (cfg.cnt_thr),
        .maddr    (cfg.maddr),
        .mdata    (cfg.mdata),
        .msg_ack  (msg_ack),
        .msg_req  (msg_req),
        .msg_addr (msg_addr),
        .msg_data (msg_data),
        .msg_done (msg_done)
    );
endmodule

// File: tb/test_irq_msg_coalescer.sv
`timescale 1ns/1ps
module test_irq_msg_coalescer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        done_valid = 1'b0;
    logic        done_irq = 1'b0;
    logic [14:0] pend_cnt = '0;
    logic        tick = 1'b0;
    logic        msg_ack = 1'b0;
    logic        msg_req;
    logic [47:0] msg_addr;
    logic [31:0] msg_data;

    int n_run  = 0;
    int n_fail = 0;
    bit seen   = 1'b0;
    logic [79:0] exp_q[$];

    localparam logic [47:0] ADDR = 48'hABCD_1234_5678;

    always #5 clk = ~clk;

    irq_msg_coalescer i_irq_msg_coalescer (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .done_valid(done_valid), .done_irq(done_irq),
        .pend_cnt(pend_cnt), .tick(tick), .msg_ack(msg_ack), .msg_req(msg_req),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input bit ok, input string req, input logic [79:0] act,
                       input logic [79:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        cyc(1);
        reg_wr_en = 1'b0;
    endtask

    task automatic complete(input bit flag);
        done_valid = 1'b1; done_irq = flag;
        cyc(1);
        done_valid = 1'b0; done_irq = 1'b0;
    endtask

    task automatic tk();
        tick = 1'b1;
        cyc(1);
        tick = 1'b0;
    endtask

    task automatic ack();
        msg_ack = 1'b1;
        cyc(1);
        msg_ack = 1'b0;
    endtask

    task automatic req_is(input bit v, input string req);
        chk(msg_req === v, req, {79'd0, msg_req}, {79'd0, v});
    endtask

    // monitor: pop one expected message for each rising request
    always @(negedge clk) begin
        if (rst) begin
            seen = 1'b0;
        end else if (msg_req && !seen) begin
            seen = 1'b1;
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R8 actual=%h expected=none", {msg_addr, msg_data});
            end else begin
                logic [79:0] e;
                e = exp_q.pop_front();
                if ({msg_addr, msg_data} !== e) begin
                    n_fail++;
                    $display("FAIL R11 actual=%h expected=%h", {msg_addr, msg_data}, e);
                end
            end
        end else if (!msg_req) begin
            seen = 1'b0;
        end
    end

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk(msg_req === 1'b0 && msg_addr === '0 && msg_data === '0, "R1",
            {msg_req, msg_addr, msg_data[30:0]}, '0);
        rst = 1'b0;
        cyc(1);
        req_is(1'b0, "R1");

        // R11 register layout
        wr(12'h014, 32'hCAFE_0001);
        wr(12'h050, 32'h1234_5678);
        wr(12'h054, 32'hFFFF_ABCD);
        wr(12'h018, 32'd4);
        wr(12'h810, 32'd3);

        // R2 count threshold exceeded
        exp_q.push_back({ADDR, 32'hCAFE_0001});
        pend_cnt = 15'd5;
        complete(1'b1);
        req_is(1'b0, "R2");
        cyc(1);
        req_is(1'b1, "R2");
        chk(msg_addr === ADDR, "R11", {32'd0, msg_addr}, {32'd0, ADDR});
        // R8 held and captured
        wr(12'h014, 32'h0000_BEEF);
        cyc(2);
        req_is(1'b1, "R8");
        chk(msg_data === 32'hCAFE_0001, "R8", {48'd0, msg_data}, {48'd0, 32'hCAFE_0001});
        ack();
        req_is(1'b0, "R9");
        cyc(5);
        req_is(1'b0, "R9");

        // R3 unflagged completion
        complete(1'b0);
        cyc(5);
        req_is(1'b0, "R3");

        // R2 below then equal to threshold
        pend_cnt = 15'd3;
        complete(1'b1);
        cyc(5);
        req_is(1'b0, "R2");
        exp_q.push_back({ADDR, 32'h0000_BEEF});
        pend_cnt = 15'd4;
        cyc(1);
        req_is(1'b1, "R2");
        ack();

        // R4 zero pending with zero threshold
        wr(12'h018, 32'd0);
        pend_cnt = 15'd0;
        complete(1'b1);
        cyc(5);
        req_is(1'b0, "R4");
        exp_q.push_back({ADDR, 32'h0000_BEEF});
        pend_cnt = 15'd1;
        cyc(1);
        req_is(1'b1, "R4");
        ack();

        // R5 timer of 3 ticks
        wr(12'h018, (32'd1 << 18) | 32'd100);
        wr(12'h810, 32'd3);
        pend_cnt = 15'd2;
        complete(1'b1);
        cyc(2); tk(); cyc(2); tk(); cyc(3);
        req_is(1'b0, "R5");
        exp_q.push_back({ADDR, 32'h0000_BEEF});
        tk();
        req_is(1'b0, "R5");
        cyc(1);
        req_is(1'b1, "R5");
        ack();

        // R7 zero timer threshold
        wr(12'h810, 32'd0);
        complete(1'b1);
        cyc(3);
        req_is(1'b0, "R7");
        exp_q.push_back({ADDR, 32'h0000_BEEF});
        tk();
        req_is(1'b0, "R7");
        cyc(1);
        req_is(1'b1, "R7");
        ack();

        // R6 timer disabled, then enabled
        wr(12'h018, 32'd100);
        complete(1'b1);
        for (int i = 0; i < 5; i++) begin
            tk(); cyc(1);
        end
        req_is(1'b0, "R6");
        wr(12'h018, (32'd1 << 18) | 32'd100);
        exp_q.push_back({ADDR, 32'h0000_BEEF});
        tk();
        req_is(1'b0, "R6");
        cyc(1);
        req_is(1'b1, "R6");
        ack();

        // R10 completion coinciding with acknowledge
        wr(12'h018, 32'd1);
        pend_cnt = 15'd3;
        exp_q.push_back({ADDR, 32'h0000_BEEF});
        exp_q.push_back({ADDR, 32'h0000_BEEF});
        exp_q.push_back({ADDR, 32'h0000_BEEF});
        complete(1'b1);
        cyc(1);
        req_is(1'b1, "R10");
        done_valid = 1'b1; done_irq = 1'b1; msg_ack = 1'b1;
        cyc(1);
        done_valid = 1'b0; done_irq = 1'b0; msg_ack = 1'b0;
        req_is(1'b0, "R10");
        cyc(1);
        req_is(1'b1, "R10");
        // R10 completion while outstanding
        complete(1'b1);
        cyc(2);
        ack();
        req_is(1'b0, "R10");
        cyc(1);
        req_is(1'b1, "R10");
        ack();
        cyc(5);
        req_is(1'b0, "R9");

        // R8 every expected message appeared exactly once
        chk(exp_q.size() == 0, "R8", 80'(exp_q.size()), 80'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule